// File: doc/BRIEF.md
# Four-Pixel 3x3 Neighbourhood Filter

This block filters an 8-bit grayscale image four pixels at a time. Upstream logic delivers three aligned 32-bit words per step, one from each of three consecutive image rows, and the block returns one 32-bit word. That word holds four filtered pixels for the middle row. A per-group mode bit selects one of two filters: the arithmetic mean of the 3x3 neighbourhood, or its median.

The neighbourhood is held in a register window six columns wide and three rows high. Two columns are carried over from the previous word of each row. The other four are the pixels of the current word. Because the window is built from registers, all 18 pixels are readable in the same cycle. The block therefore accepts a new group on every cycle in which the output side is not stalled. The first word of every image row only primes the window. Whole-row line buffering, border padding and frame control belong to the surrounding logic.

Top module: `quad_window_filter`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: in_ready is high exactly when out_valid is low or out_ready is high. A group is accepted on a rising clock edge where in_valid and in_ready are both high.
- R3: An accepted group with row_start high produces no output word. It only loads the two retained columns of each row from byte lanes 2 and 3 of its words.
- R4: An accepted group with row_start low produces exactly one output word. That word is valid in the cycle after acceptance. When nothing new is produced and out_ready is high, out_valid drops.
- R5: Pixel lanes are as follows: byte lane j (bits 8j+7:8j) is pixel j, and lane 0 is the leftmost. The window columns, from left to right, are lanes 2 and 3 of the previous word of the row, then lanes 0 to 3 of the current word. Output lane k is the filter over window columns k to k+2 of all three rows.
- R6: With mode_median low, an output pixel is floor(S*7282/65536), where S is the sum of the nine pixels, saturated to 255.
- R7: With mode_median high, an output pixel is the fifth smallest of the nine pixels.
- R8: mode_median is taken at the acceptance edge of each group. Changing it between groups affects only the groups accepted afterwards.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_pixels stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block can take a group this cycle |
| row_start | input | 1 | Group is the first word of an image row |
| mode_median | input | 1 | 1 selects median, 0 selects mean |
| row_top | input | 32 | Four pixels of the upper row |
| row_mid | input | 32 | Four pixels of the centre row |
| row_bot | input | 32 | Four pixels of the lower row |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |
| out_pixels | output | 32 | Four filtered pixels, lane k from window centre k+1 |

## Verification
The embedded properties assume that out_ready may fall at any time. They also assume that the input side follows the handshake, so a group counts only in a cycle where in_ready is high. The bench presents each group and holds it until it is accepted. It drops out_ready at random so that stalls land both on fresh results and on held ones. It flips mode_median from group to group. It mixes random rows with flat, ramped, all-zero and all-255 rows, so that the mean saturation and the median extremes are both reached.

// File: rtl/quad_window_filter.sv
module quad_window_filter #(
  parameter int LANES      = 4,
  parameter int PIX_W      = 8,
  parameter int MEAN_MUL   = 7282,
  parameter int MEAN_SHIFT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   row_start,
  input  logic                   mode_median,
  input  logic [LANES*PIX_W-1:0] row_top,
  input  logic [LANES*PIX_W-1:0] row_mid,
  input  logic [LANES*PIX_W-1:0] row_bot,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_pixels
);
  localparam int WORD_W  = LANES * PIX_W;
  localparam int ROWS    = 3;
  localparam int KEEP    = 2;
  localparam int COLS    = LANES + KEEP;
  localparam int TAPS    = ROWS * 3;
  localparam int SUM_W   = PIX_W + 4;
  localparam int PROD_W  = SUM_W + $clog2(MEAN_MUL + 1);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  logic [WORD_W-1:0] cur [ROWS];
  logic [PIX_W-1:0]  keep_q [ROWS][KEEP];
  logic [PIX_W-1:0]  win [ROWS][COLS];
  logic [WORD_W-1:0] result;
  logic              accept;

  assign cur[0] = row_top;
  assign cur[1] = row_mid;
  assign cur[2] = row_bot;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      for (int j = 0; j < KEEP; j++) win[r][j] = keep_q[r][j];
      for (int j = 0; j < LANES; j++) win[r][j+KEEP] = cur[r][j*PIX_W +: PIX_W];
    end
  end

  function automatic logic [PIX_W-1:0] median9(input logic [TAPS*PIX_W-1:0] v);
    logic [PIX_W-1:0] a [TAPS];
    logic [PIX_W-1:0] t;
    for (int i = 0; i < TAPS; i++) a[i] = v[i*PIX_W +: PIX_W];
    for (int p = 0; p < TAPS; p++) begin
      for (int i = 0; i < TAPS - 1; i++) begin
        if ((i % 2) == (p % 2) && a[i] > a[i+1]) begin
          t      = a[i];
          a[i]   = a[i+1];
          a[i+1] = t;
        end
      end
    end
    return a[TAPS/2];
  endfunction

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [TAPS*PIX_W-1:0] taps;
    logic [SUM_W-1:0]      sum;
    logic [PROD_W-1:0]     prod;
    logic [PROD_W-1:0]     quo;
    logic [PIX_W-1:0]      mean_px;
    logic [PIX_W-1:0]      med_px;

    always_comb begin
      sum = '0;
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < 3; c++) begin
          taps[(r*3+c)*PIX_W +: PIX_W] = win[r][k+c];
          sum = sum + SUM_W'(win[r][k+c]);
        end
      end
    end

    assign prod    = PROD_W'(sum) * PROD_W'(MEAN_MUL);
    assign quo     = prod >> MEAN_SHIFT;
    assign mean_px = (quo > PROD_W'(PIX_MAX)) ? PIX_W'(PIX_MAX) : quo[PIX_W-1:0];
    assign med_px  = median9(taps);
    assign result[k*PIX_W +: PIX_W] = mode_median ? med_px : mean_px;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_pixels <= '0;
      for (int r = 0; r < ROWS; r++)
        for (int j = 0; j < KEEP; j++) keep_q[r][j] <= '0;
    end else begin
      if (accept) begin
        for (int r = 0; r < ROWS; r++)
          for (int j = 0; j < KEEP; j++)
            keep_q[r][j] <= cur[r][(LANES-KEEP+j)*PIX_W +: PIX_W];
      end
      if (accept && !row_start) begin
        out_valid  <= 1'b1;
        out_pixels <= result;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pixels)); // R9

  AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2

  AST_ROWSTART_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && row_start |=> !out_valid); // R3

  AST_GROUP_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !row_start |=> out_valid); // R4

  AST_DRAIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R4

endmodule

// File: tb/test_quad_window_filter.sv
`timescale 1ns/1ps
module test_quad_window_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        row_start = 1'b0;
  logic        mode_median = 1'b0;
  logic [31:0] row_top = '0, row_mid = '0, row_bot = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pixels;

  always #2 clk = ~clk;

  quad_window_filter i_quad_window_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .row_start(row_start), .mode_median(mode_median),
    .row_top(row_top), .row_mid(row_mid), .row_bot(row_bot),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixels(out_pixels));

  int checks = 0;
  int fails = 0;
  int stall_pct = 30;
  logic [31:0] exp_q[$];
  bit          med_q[$];
  int          prev[3][2];
  bit          was_stalled = 0;
  logic [31:0] held_word = '0;
  bit          finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pix(input logic [31:0] w, input int j);
    return int'(w[j*8 +: 8]);
  endfunction

  function automatic int ref_filter(input int v[9], input bit med);
    int s = 0;
    int a[9];
    int t;
    if (!med) begin
      for (int i = 0; i < 9; i++) s += v[i];
      s = (s * 7282) / 65536;
      return (s > 255) ? 255 : s;
    end
    a = v;
    for (int i = 1; i < 9; i++)
      for (int j = i; j > 0 && a[j-1] > a[j]; j--) begin
        t = a[j]; a[j] = a[j-1]; a[j-1] = t;
      end
    return a[4];
  endfunction

  task automatic model_accept(input logic [31:0] t, input logic [31:0] m,
                              input logic [31:0] b, input bit rs, input bit md);
    logic [31:0] words[3];
    int w[3][6];
    int v[9];
    logic [31:0] res = '0;
    words[0] = t; words[1] = m; words[2] = b;
    if (!rs) begin
      for (int r = 0; r < 3; r++) begin
        w[r][0] = prev[r][0]; w[r][1] = prev[r][1];
        for (int j = 0; j < 4; j++) w[r][j+2] = pix(words[r], j);
      end
      for (int k = 0; k < 4; k++) begin
        for (int r = 0; r < 3; r++)
          for (int c = 0; c < 3; c++) v[r*3+c] = w[r][k+c];
        res[k*8 +: 8] = 8'(ref_filter(v, md));
      end
      exp_q.push_back(res);
      med_q.push_back(md);
    end
    for (int r = 0; r < 3; r++) begin
      prev[r][0] = pix(words[r], 2);
      prev[r][1] = pix(words[r], 3);
    end
  endtask

  task automatic observe();
    check("R2 in_ready", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
    if (was_stalled) begin
      check("R9 valid held", {31'd0, out_valid}, 32'd1);
      check("R9 data held", out_pixels, held_word);
    end
    was_stalled = out_valid && !out_ready;
    held_word = out_pixels;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3 R4 unexpected output actual=%h expected=none", out_pixels);
      end else begin
        bit md = med_q.pop_front();
        logic [31:0] e = exp_q.pop_front();
        if (md) check("R5 R7 R8 median word", out_pixels, e);
        else check("R5 R6 R8 mean word", out_pixels, e);
      end
    end
  endtask

  task automatic send(input logic [31:0] t, input logic [31:0] m, input logic [31:0] b,
                      input bit rs, input bit md);
    bit done = 0;
    while (!done) begin
      @(negedge clk);
      in_valid = 1'b1; row_top = t; row_mid = m; row_bot = b;
      row_start = rs; mode_median = md;
      out_ready = ($urandom % 100) >= stall_pct;
      #1;
      observe();
      if (in_ready) begin
        model_accept(t, m, b, rs, md);
        done = 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      mode_median = ~mode_median;
      out_ready = ($urandom % 100) >= stall_pct;
      #1;
      observe();
    end
  endtask

  function automatic logic [31:0] make_word(input int pat, input int row, input int col);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) begin
      case (pat)
        0: w[j*8 +: 8] = 8'($urandom);
        1: w[j*8 +: 8] = 8'(37 + row);
        2: w[j*8 +: 8] = 8'((col*4 + j) * 9 + row * 3);
        3: w[j*8 +: 8] = 8'd255;
        4: w[j*8 +: 8] = 8'd0;
        default: w[j*8 +: 8] = ((j + row + col) % 2) ? 8'd255 : 8'd0;
      endcase
    end
    return w;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid at reset", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready at reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int row = 0; row < 60; row++) begin
      int pat = row % 6;
      int words = 3 + (row % 6);
      bit mode_fixed = row[0];
      stall_pct = (row < 20) ? 0 : ((row < 40) ? 30 : 70);
      for (int c = 0; c < words; c++) begin
        bit md = (row >= 30) ? bit'($urandom % 2) : mode_fixed;
        send(make_word(pat, 0, c), make_word(pat, 1, c), make_word(pat, 2, c), c == 0, md);
        if ((c % 3) == 2) idle(1);
      end
    end
    stall_pct = 0;
    idle(6);
    check("R4 all outputs delivered", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule